// File: doc/BRIEF.md
# Buffered Character Relay

This block moves characters from a producer device to a consumer device that may run at a different speed. The producer raises a level `src_ready` while it offers a character on `src_char`. The relay accepts it and answers with a one-cycle `src_take` pulse. That pulse tells the producer to drop `src_ready`, and it may then fetch its next character. On the other side the relay owns a busy flag, `dst_busy`. It places a character on `dst_char` and sets the flag. The consumer clears the flag again by pulsing `dst_done`.

Between the two sides the characters wait in a circular queue. Arrivals are written at the tail and departures are read from the head, and both pointers wrap at the end of the storage. One slot is always kept empty: equal pointers mean the queue is empty, so a queue of `DEPTH` slots holds at most `DEPTH-1` characters. A character that arrives when the queue is full is still acknowledged, but it is discarded and `ovf_flag` is set. The flag stays set until `ovf_clr` is pulsed.

Top module: `char_relay`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `src_take`, `dst_busy` and `ovf_flag` are 0.
- R2: When `src_ready` is 1 at a clock edge and `src_take` is 0, `src_take` is 1 after that edge for exactly one cycle, and `src_char` is captured at that edge. The producer must drop `src_ready` before the edge that follows the pulse.
- R3: When `dst_busy` is 0 and the queue holds at least one character at an edge, then after that edge `dst_busy` is 1 and `dst_char` carries the character at the head of the queue. That character leaves the queue.
- R4: While `dst_busy` is 1, `dst_char` does not change and no further character is removed. `dst_busy` becomes 0 after the first edge at which `dst_done` is 1, and a new write can start only at a later edge.
- R5: Characters reach `dst_char` in the order they were accepted, with no losses other than those of R6, across any number of pointer wraps.
- R6: The queue holds at most `DEPTH-1` characters. A character accepted while `DEPTH-1` are stored, counted at the start of the cycle, is dropped and sets `ovf_flag` after that edge.
- R7: `ovf_flag` stays 1 until an edge at which `ovf_clr` is 1 and no new overflow occurs. An overflow in the same cycle as `ovf_clr` leaves the flag at 1.
- R8: When one character is accepted and another is removed in the same cycle, the occupancy does not change. When input and output rates are balanced, no overflow occurs.
- R9: When the queue is empty and `dst_busy` is 0, `dst_busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ready | input | 1 | Producer has a character on offer |
| src_char | input | DATA_W | Offered character |
| src_take | output | 1 | One-cycle pulse: character taken, producer drops its status |
| dst_char | output | DATA_W | Character being written to the consumer |
| dst_busy | output | 1 | Write in progress, set by the relay |
| dst_done | input | 1 | Consumer pulse that ends the write and clears `dst_busy` |
| ovf_flag | output | 1 | Sticky overflow indicator |
| ovf_clr | input | 1 | Pulse that clears `ovf_flag` |

## Verification
The bench builds the relay with `DATA_W=8` and `DEPTH=4`. With only three usable slots, a slow consumer fills the queue within a few characters, so dropping on a full queue and the sticky flag are exercised early. The same small depth makes the pointers wrap many times over a short stream, and balanced rates make accept and remove coincide often. A behavioural queue model predicts every output on every cycle, and the stream the consumer receives is compared in full against the characters the model kept.

// File: rtl/relay_pkg.sv
`timescale 1ns/1ps
package relay_pkg;
  // Advance a ring index by one, wrapping at the storage size.
  function automatic int unsigned ring_next(int unsigned idx, int unsigned size);
    return (idx + 1 == size) ? 0 : idx + 1;
  endfunction

  // Number of stored entries between read index and write index.
  function automatic int unsigned ring_used(int unsigned rd, int unsigned wr, int unsigned size);
    return (wr >= rd) ? (wr - rd) : (size - rd + wr);
  endfunction
endpackage

// File: rtl/relay_accept.sv
`timescale 1ns/1ps
module relay_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic src_ready,
  output logic take,
  output logic src_take
);
  // A character is taken only if no acknowledge is still outstanding.
  assign take = src_ready & ~src_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_take <= 1'b0;
    else        src_take <= take;
  end
endmodule

// File: rtl/relay_ring.sv
`timescale 1ns/1ps
module relay_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  used
);
  import relay_pkg::*;

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;

  assign empty   = (head_q == tail_q);
  assign full    = (ring_next(32'(tail_q), DEPTH) == 32'(head_q));
  assign used    = CNT_W'(ring_used(32'(head_q), 32'(tail_q), DEPTH));
  assign rd_data = slots[head_q];

  always_ff @(posedge clk) begin
    if (wr_en) slots[tail_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (wr_en) tail_q <= PTR_W'(ring_next(32'(tail_q), DEPTH));
      if (rd_en) head_q <= PTR_W'(ring_next(32'(head_q), DEPTH));
    end
  end
endmodule

// File: rtl/relay_emit.sv
`timescale 1ns/1ps
module relay_emit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              have_char,
  input  logic [DATA_W-1:0] head_char,
  input  logic              dst_done,
  output logic              pop,
  output logic              dst_busy,
  output logic [DATA_W-1:0] dst_char
);
  // A new write starts only once the busy flag has been seen low.
  assign pop = ~dst_busy & have_char;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_busy <= 1'b0;
      dst_char <= '0;
    end else if (pop) begin
      dst_busy <= 1'b1;
      dst_char <= head_char;
    end else if (dst_busy && dst_done) begin
      dst_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/char_relay.sv
`timescale 1ns/1ps
module char_relay #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_ready,
  input  logic [DATA_W-1:0] src_char,
  output logic              src_take,
  output logic [DATA_W-1:0] dst_char,
  output logic              dst_busy,
  input  logic              dst_done,
  output logic              ovf_flag,
  input  logic              ovf_clr
);
  // Named internal events, observed by the bound checker.
  logic             take, push, pop, overflow, ring_full, ring_empty;
  logic [DATA_W-1:0] head_char;
  logic [CNT_W-1:0]  fill;

  assign push     = take & ~ring_full;
  assign overflow = take &  ring_full;

  relay_accept u_accept (
    .clk(clk), .rst_n(rst_n), .src_ready(src_ready),
    .take(take), .src_take(src_take)
  );

  relay_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push), .wr_data(src_char),
    .rd_en(pop), .rd_data(head_char),
    .full(ring_full), .empty(ring_empty), .used(fill)
  );

  relay_emit #(.DATA_W(DATA_W)) u_emit (
    .clk(clk), .rst_n(rst_n),
    .have_char(~ring_empty), .head_char(head_char),
    .dst_done(dst_done), .pop(pop),
    .dst_busy(dst_busy), .dst_char(dst_char)
  );

  // Sticky overflow indicator; a new overflow beats a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (overflow) ovf_flag <= 1'b1;
    else if (ovf_clr)  ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/char_relay_checker.sv
`timescale 1ns/1ps
module char_relay_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_take,
  input logic              dst_busy,
  input logic              dst_done,
  input logic [DATA_W-1:0] dst_char,
  input logic              ovf_flag,
  input logic              ovf_clr,
  input logic              overflow,
  input logic              push,
  input logic              pop,
  input logic [CNT_W-1:0]  fill
);
  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    src_take |=> !src_take); // R2

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_busy && !dst_done) |=> (dst_busy && $stable(dst_char))); // R4

  AST_DONE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_busy && dst_done) |=> !dst_busy); // R4

  AST_OVERFLOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> ovf_flag); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R7

  AST_BOTH_KEEP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(fill)); // R8

  AST_EMPTY_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && !dst_busy) |=> !dst_busy); // R9

  always_comb begin
    if (rst_n) begin
      AST_NO_OVERFLOW: assert (32'(fill) <= DEPTH - 1); // R6
    end
  end
endmodule

bind char_relay char_relay_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_take(src_take), .dst_busy(dst_busy),
  .dst_done(dst_done), .dst_char(dst_char), .ovf_flag(ovf_flag),
  .ovf_clr(ovf_clr), .overflow(overflow), .push(push), .pop(pop), .fill(fill)
);

// File: tb/char_relay_test.sv
`timescale 1ns/1ps
module char_relay_test;
  localparam int DW = 8;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_ready = 1'b0;
  logic [DW-1:0] src_char = '0;
  logic src_take, dst_busy, ovf_flag;
  logic [DW-1:0] dst_char;
  logic dst_done = 1'b0;
  logic ovf_clr = 1'b0;

  always #2.5 clk = ~clk;

  char_relay #(.DATA_W(DW), .DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .src_char(src_char),
    .src_take(src_take), .dst_char(dst_char), .dst_busy(dst_busy),
    .dst_done(dst_done), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped on each rising edge.
  logic [DW-1:0] m_q[$];
  logic [DW-1:0] kept_q[$];
  bit m_take = 0, m_busy = 0, m_ovf = 0;
  logic [DW-1:0] m_char = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_take = 0; m_busy = 0; m_ovf = 0; m_char = '0;
    end else begin
      bit take_now, was_full, start_now;
      take_now  = src_ready && !m_take;
      was_full  = (m_q.size() == DP - 1);
      start_now = !m_busy && (m_q.size() > 0);
      if (m_busy && dst_done) m_busy = 0;
      else if (start_now) begin m_busy = 1; m_char = m_q.pop_front(); end
      if (take_now) begin
        if (was_full) m_ovf = 1;
        else begin m_q.push_back(src_char); kept_q.push_back(src_char); end
      end else if (ovf_clr) m_ovf = 0;
      if (take_now && was_full) m_ovf = 1;
      m_take = take_now;
    end
  end

  // Cycle-by-cycle comparison against the model.
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      check("R2 take pulse", src_take, m_take);
      check("R3/R4 busy", dst_busy, m_busy);
      check("R6/R7 overflow flag", ovf_flag, m_ovf);
      if (m_busy) check("R5 character", dst_char, m_char);
    end
  end

  // Producer device model.
  logic [DW-1:0] send_q[$];
  int src_gap = 0;
  initial begin
    int gap = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) src_ready = 0;
      else if (src_take) begin src_ready = 0; gap = 0; end
      else if (!src_ready && send_q.size() > 0) begin
        if (gap >= src_gap) begin src_char = send_q.pop_front(); src_ready = 1; end
        else gap++;
      end
    end
  end

  // Consumer device model.
  logic [DW-1:0] rx_q[$];
  int dst_lat = 0;
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin dst_done = 0; wait_cnt = 0; end
      else if (dst_busy && !dst_done) begin
        if (wait_cnt >= dst_lat) begin dst_done = 1; rx_q.push_back(dst_char); wait_cnt = 0; end
        else wait_cnt++;
      end else dst_done = 0;
    end
  end

  task automatic feed(int n, int base);
    for (int i = 0; i < n; i++) send_q.push_back(DW'(base + i));
  endtask

  task automatic drain(int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (send_q.size() == 0 && !src_ready && m_q.size() == 0 && !m_busy) break;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset take", src_take, 0);
    check("R1 reset busy", dst_busy, 0);
    check("R1 reset flag", ovf_flag, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset busy", dst_busy, 0);
    check("R9 idle when empty", dst_busy, 0);

    // Fast consumer, paced producer.
    src_gap = 2; dst_lat = 0;
    feed(6, 8'h10);
    drain(200);
    check("R6 no overflow at low rate", ovf_flag, 0);

    // Slow consumer, fast producer: queue fills and drops.
    src_gap = 0; dst_lat = 30;
    feed(9, 8'h40);
    drain(800);
    check("R6 overflow reported", ovf_flag, 1);
    repeat (5) @(negedge clk);
    check("R7 flag sticky", ovf_flag, 1);
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
    check("R7 flag cleared", ovf_flag, 0);

    // Balanced rates: frequent simultaneous accept and remove.
    src_gap = 1; dst_lat = 1;
    feed(24, 8'h80);
    drain(600);
    check("R8 balanced no overflow", ovf_flag, 0);

    // Quick refill with wrap, consumer one cycle slower.
    src_gap = 0; dst_lat = 2;
    feed(12, 8'hC0);
    drain(600);

    repeat (5) @(negedge clk);
    check("R9 stays idle", dst_busy, 0);
    check("R5 stream length", rx_q.size(), kept_q.size());
    for (int i = 0; i < rx_q.size() && i < kept_q.size(); i++)
      check("R5 stream order", rx_q[i], kept_q[i]);
    check("R6 drops occurred", (kept_q.size() < 51) ? 1 : 0, 1);
    summary();
  end
endmodule